// File: doc/BRIEF.md
# Pre-Trade Risk Limit Checker

This block gates outgoing orders. Each order request carries a side, a quantity and an instrument index. It is checked against five configured limits: the largest single order, the largest absolute net position that would result, the loss booked so far in the current minute, the loss for the day, and the number of orders already released in the current second. The block answers with a pass or reject flag and a reason code. The answer always arrives the same number of cycles after the request. Cancel requests are never blocked.

To make these checks, the block keeps running state. Trade fill reports update long and short totals for each instrument, together with the day's signed P&L. Losing fills also add to a per-minute loss accumulator. A counter records the orders that passed in the current second. A one-second tick, a one-minute tick and a day-reset input each restart their own window. The limit values are static configuration inputs.

Top module: `risk_gate`

## Requirements
- R1: A non-cancel order whose quantity is strictly greater than `lim_order_qty` is rejected with reason code 1.
- R2: The projected net position is the instrument's net position plus the quantity for a buy (`req_sell`=0), or minus the quantity for a sell. If the absolute value of the projection is strictly greater than `lim_pos`, the order is rejected with reason code 2.
- R3: The minute loss is the sum of the magnitudes of negative fill P&L values since the last minute tick; positive P&L values do not reduce it. If the minute loss is strictly greater than `lim_min_loss`, the order is rejected with reason code 3.
- R4: If the signed daily P&L is strictly below minus `lim_day_loss`, the order is rejected with reason code 4.
- R5: If the number of orders that passed in the current second is already equal to or greater than `lim_rate`, the order is rejected with reason code 5. With a limit of N, N orders pass in each second.
- R6: A cancel request (`req_cancel`=1) always passes with reason code 0, whatever the state and limits are.
- R7: A fill adds its quantity to the long total of its instrument for a buy, or to the short total for a sell. Net position is long minus short. The fill's P&L is added to the daily P&L. Requests see fills from earlier cycles.
- R8: `tick_sec` clears the order-rate count, `tick_min` clears the minute loss and `day_reset` clears the daily P&L. A fill or pass in the same cycle as the clear is counted in the new window.
- R9: The result (`res_valid`, `res_pass`, `res_reason`) appears exactly two cycles after the request cycle. When several checks fail, the reason code is the lowest one that applies: 1, 2, 3, 4, 5 in that order. Reason 0 means pass.
- R10: Only new orders that pass increase the order-rate count. Rejected orders and cancels do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Order request present |
| req_cancel | input | 1 | Request is a cancel |
| req_sell | input | 1 | Side: 0 buy, 1 sell |
| req_qty | input | QTY_W | Order quantity |
| req_inst | input | IDX_W | Instrument index |
| fill_valid | input | 1 | Fill report present |
| fill_sell | input | 1 | Fill side: 0 buy, 1 sell |
| fill_qty | input | QTY_W | Filled quantity |
| fill_inst | input | IDX_W | Fill instrument index |
| fill_pnl | input | PNL_W | Signed realized P&L of the fill |
| tick_sec | input | 1 | One-second window pulse |
| tick_min | input | 1 | One-minute window pulse |
| day_reset | input | 1 | Clears daily P&L |
| lim_order_qty | input | QTY_W | Largest allowed order quantity |
| lim_pos | input | POS_W | Largest allowed absolute projected position |
| lim_min_loss | input | PNL_W | Per-minute loss limit (magnitude) |
| lim_day_loss | input | PNL_W | Daily loss limit (magnitude) |
| lim_rate | input | CNT_W | Orders allowed per second |
| res_valid | output | 1 | Result present |
| res_pass | output | 1 | Order released |
| res_reason | output | 3 | Reject reason code, 0 on pass |

## Verification
Any corrupted internal state shows up at the ports on the next order request that the state can affect. The verdict appears two cycles later as a wrong reason code. A bad long or short total gives a wrong position verdict near the limit of ±`lim_pos`. A minute or daily accumulator that fails to clear or to add shows up as a reason 3 or 4 one fill away from the threshold. A rate counter that counts cancels or rejected orders gives an early reason 5. For this reason the tests place orders just inside and just outside each limit.

// File: rtl/risk_gate_pkg.sv
package risk_gate_pkg;

    typedef enum logic [2:0] {
        RSN_NONE = 3'd0,
        RSN_SIZE = 3'd1,
        RSN_POS  = 3'd2,
        RSN_MIN  = 3'd3,
        RSN_DAY  = 3'd4,
        RSN_RATE = 3'd5
    } reason_t;

    typedef struct packed {
        logic size;
        logic pos;
        logic min_loss;
        logic day_loss;
        logic rate;
    } fails_t;

    typedef struct packed {
        logic    pass;
        reason_t reason;
    } verdict_t;

    // Lowest-numbered failing check wins
    function automatic verdict_t pick_verdict(input fails_t f);
        verdict_t v;
        v.pass   = 1'b0;
        if (f.size)          v.reason = RSN_SIZE;
        else if (f.pos)      v.reason = RSN_POS;
        else if (f.min_loss) v.reason = RSN_MIN;
        else if (f.day_loss) v.reason = RSN_DAY;
        else if (f.rate)     v.reason = RSN_RATE;
        else begin
            v.pass   = 1'b1;
            v.reason = RSN_NONE;
        end
        return v;
    endfunction

endpackage

// File: rtl/risk_pos_book.sv
module risk_pos_book #(
    parameter int N_INST = 4,
    parameter int QTY_W  = 16,
    parameter int POS_W  = 24,
    localparam int IDX_W = (N_INST > 1) ? $clog2(N_INST) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fill_valid,
    input  logic                    fill_sell,
    input  logic [QTY_W-1:0]        fill_qty,
    input  logic [IDX_W-1:0]        fill_inst,
    input  logic [IDX_W-1:0]        rd_inst,
    output logic signed [POS_W-1:0] net_pos
);
    logic signed [POS_W-1:0] net_arr [N_INST];

    for (genvar i = 0; i < N_INST; i++) begin : g_inst
        logic [POS_W-1:0] long_tot;
        logic [POS_W-1:0] short_tot;
        logic             hit;

        assign hit = fill_valid && (fill_inst == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                long_tot  <= '0;
                short_tot <= '0;
            end else if (hit) begin
                if (fill_sell) short_tot <= short_tot + POS_W'(fill_qty);
                else           long_tot  <= long_tot  + POS_W'(fill_qty);
            end
        end

        assign net_arr[i] = $signed(long_tot - short_tot);
    end

    assign net_pos = net_arr[rd_inst];
endmodule

// File: rtl/risk_pnl_track.sv
module risk_pnl_track #(
    parameter int PNL_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fill_valid,
    input  logic signed [PNL_W-1:0] fill_pnl,
    input  logic                    tick_min,
    input  logic                    day_reset,
    output logic [PNL_W-1:0]        min_loss,
    output logic signed [PNL_W-1:0] day_pnl
);
    logic [PNL_W-1:0]        loss_add;
    logic signed [PNL_W-1:0] pnl_add;

    assign pnl_add  = fill_valid ? fill_pnl : '0;
    assign loss_add = (fill_valid && fill_pnl[PNL_W-1]) ? PNL_W'(-fill_pnl) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            min_loss <= '0;
            day_pnl  <= '0;
        end else begin
            min_loss <= tick_min  ? loss_add : min_loss + loss_add;
            day_pnl  <= day_reset ? pnl_add  : day_pnl + pnl_add;
        end
    end
endmodule

// File: rtl/risk_rate_ctr.sv
module risk_rate_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_sec,
    input  logic             count_en,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                            cnt <= '0;
        else if (tick_sec)                  cnt <= count_en ? CNT_W'(1) : '0;
        else if (count_en && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/risk_gate.sv
module risk_gate
    import risk_gate_pkg::*;
#(
    parameter int N_INST = 4,
    parameter int QTY_W  = 16,
    parameter int POS_W  = 24,
    parameter int PNL_W  = 32,
    parameter int CNT_W  = 8,
    localparam int IDX_W = (N_INST > 1) ? $clog2(N_INST) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_cancel,
    input  logic                    req_sell,
    input  logic [QTY_W-1:0]        req_qty,
    input  logic [IDX_W-1:0]        req_inst,
    input  logic                    fill_valid,
    input  logic                    fill_sell,
    input  logic [QTY_W-1:0]        fill_qty,
    input  logic [IDX_W-1:0]        fill_inst,
    input  logic signed [PNL_W-1:0] fill_pnl,
    input  logic                    tick_sec,
    input  logic                    tick_min,
    input  logic                    day_reset,
    input  logic [QTY_W-1:0]        lim_order_qty,
    input  logic [POS_W-1:0]        lim_pos,
    input  logic [PNL_W-1:0]        lim_min_loss,
    input  logic [PNL_W-1:0]        lim_day_loss,
    input  logic [CNT_W-1:0]        lim_rate,
    output logic                    res_valid,
    output logic                    res_pass,
    output logic [2:0]              res_reason
);
    localparam int PW = POS_W + 1;
    localparam int DW = PNL_W + 1;

    logic signed [POS_W-1:0] net_pos;
    logic [PNL_W-1:0]        min_loss;
    logic signed [PNL_W-1:0] day_pnl;
    logic [CNT_W-1:0]        rate_cnt;
    logic                    count_en;

    risk_pos_book #(.N_INST(N_INST), .QTY_W(QTY_W), .POS_W(POS_W)) u_book (
        .clk(clk), .rst(rst),
        .fill_valid(fill_valid), .fill_sell(fill_sell),
        .fill_qty(fill_qty), .fill_inst(fill_inst),
        .rd_inst(req_inst), .net_pos(net_pos)
    );

    risk_pnl_track #(.PNL_W(PNL_W)) u_pnl (
        .clk(clk), .rst(rst),
        .fill_valid(fill_valid), .fill_pnl(fill_pnl),
        .tick_min(tick_min), .day_reset(day_reset),
        .min_loss(min_loss), .day_pnl(day_pnl)
    );

    risk_rate_ctr #(.CNT_W(CNT_W)) u_rate (
        .clk(clk), .rst(rst),
        .tick_sec(tick_sec), .count_en(count_en), .cnt(rate_cnt)
    );

    // Projected position check
    logic signed [PW-1:0] qty_ext;
    logic signed [PW-1:0] proj;
    logic [PW-1:0]        proj_abs;
    assign qty_ext  = $signed({{(PW-QTY_W){1'b0}}, req_qty});
    assign proj     = $signed({net_pos[POS_W-1], net_pos}) + (req_sell ? -qty_ext : qty_ext);
    assign proj_abs = proj[PW-1] ? PW'(-proj) : PW'(proj);

    // Daily loss floor
    logic signed [DW-1:0] day_ext;
    logic signed [DW-1:0] day_floor;
    assign day_ext   = $signed({day_pnl[PNL_W-1], day_pnl});
    assign day_floor = -$signed({1'b0, lim_day_loss});

    fails_t   fails;
    verdict_t verdict;

    always_comb begin
        fails.size     = req_qty > lim_order_qty;
        fails.pos      = proj_abs > {1'b0, lim_pos};
        fails.min_loss = min_loss > lim_min_loss;
        fails.day_loss = day_ext < day_floor;
        fails.rate     = rate_cnt >= lim_rate;
        verdict        = req_cancel ? '{pass: 1'b1, reason: RSN_NONE} : pick_verdict(fails);
    end

    assign count_en = req_valid && !req_cancel && verdict.pass;

    // Two-stage result pipeline
    logic     s1_valid, s2_valid;
    verdict_t s1_v, s2_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s2_valid <= 1'b0;
            s1_v     <= '{pass: 1'b0, reason: RSN_NONE};
            s2_v     <= '{pass: 1'b0, reason: RSN_NONE};
        end else begin
            s1_valid <= req_valid;
            s1_v     <= req_valid ? verdict : '{pass: 1'b0, reason: RSN_NONE};
            s2_valid <= s1_valid;
            s2_v     <= s1_v;
        end
    end

    assign res_valid  = s2_valid;
    assign res_pass   = s2_v.pass;
    assign res_reason = s2_v.reason;
endmodule

// File: rtl/risk_gate_chk.sv
module risk_gate_chk #(
    parameter int QTY_W = 16,
    parameter int PNL_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_cancel,
    input logic [QTY_W-1:0] req_qty,
    input logic [QTY_W-1:0] lim_order_qty,
    input logic             tick_min,
    input logic             fill_valid,
    input logic [PNL_W-1:0] min_loss,
    input logic             res_valid,
    input logic             res_pass,
    input logic [2:0]       res_reason
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)           age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    p_latency_r9: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (res_valid == $past(req_valid, 2)));

    p_cancel_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(req_valid && req_cancel, 2)) |-> (res_pass && res_reason == 3'd0));

    p_size_reject_r1: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && $past(req_valid && !req_cancel && (req_qty > lim_order_qty), 2))
        |-> (!res_pass && res_reason == 3'd1));

    p_min_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && $past(tick_min && !fill_valid)) |-> (min_loss == '0));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_pass && res_reason == 3'd0));
endmodule

bind risk_gate risk_gate_chk #(.QTY_W(QTY_W), .PNL_W(PNL_W)) u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_cancel(req_cancel),
    .req_qty(req_qty), .lim_order_qty(lim_order_qty),
    .tick_min(tick_min), .fill_valid(fill_valid),
    .min_loss(min_loss),
    .res_valid(res_valid), .res_pass(res_pass), .res_reason(res_reason)
);

// File: tb/risk_gate_tb.sv
module risk_gate_tb;
    localparam int QTY_W = 16;
    localparam int POS_W = 24;
    localparam int PNL_W = 32;
    localparam int CNT_W = 8;
    localparam int IDX_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 0, req_cancel = 0, req_sell = 0;
    logic [QTY_W-1:0] req_qty = '0;
    logic [IDX_W-1:0] req_inst = '0;
    logic fill_valid = 0, fill_sell = 0;
    logic [QTY_W-1:0] fill_qty = '0;
    logic [IDX_W-1:0] fill_inst = '0;
    logic signed [PNL_W-1:0] fill_pnl = '0;
    logic tick_sec = 0, tick_min = 0, day_reset = 0;
    logic [QTY_W-1:0] lim_order_qty = 16'd100;
    logic [POS_W-1:0] lim_pos = 24'd80;
    logic [PNL_W-1:0] lim_min_loss = 32'd500;
    logic [PNL_W-1:0] lim_day_loss = 32'd1000;
    logic [CNT_W-1:0] lim_rate = 8'd200;
    logic res_valid, res_pass;
    logic [2:0] res_reason;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    risk_gate u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_cancel(req_cancel), .req_sell(req_sell),
        .req_qty(req_qty), .req_inst(req_inst),
        .fill_valid(fill_valid), .fill_sell(fill_sell), .fill_qty(fill_qty),
        .fill_inst(fill_inst), .fill_pnl(fill_pnl),
        .tick_sec(tick_sec), .tick_min(tick_min), .day_reset(day_reset),
        .lim_order_qty(lim_order_qty), .lim_pos(lim_pos),
        .lim_min_loss(lim_min_loss), .lim_day_loss(lim_day_loss),
        .lim_rate(lim_rate),
        .res_valid(res_valid), .res_pass(res_pass), .res_reason(res_reason)
    );

    typedef struct packed {
        logic             cancel;
        logic             sell;
        logic [QTY_W-1:0] qty;
        logic [IDX_W-1:0] inst;
        logic             pass;
        logic [2:0]       reason;
    } vec_t;

    // Fresh state, lim_order_qty=100, lim_pos=80
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 16'd50,  2'd0, 1'b1, 3'd0},  // R9 plain pass
        '{1'b0, 1'b0, 16'd101, 2'd0, 1'b0, 3'd1},  // R1 + R9 size beats position
        '{1'b0, 1'b0, 16'd80,  2'd2, 1'b1, 3'd0},  // R2 boundary buy
        '{1'b0, 1'b1, 16'd81,  2'd3, 1'b0, 3'd2},  // R2 sell beyond
        '{1'b0, 1'b0, 16'd90,  2'd0, 1'b0, 3'd2},  // R2 buy beyond
        '{1'b1, 1'b0, 16'd500, 2'd0, 1'b1, 3'd0},  // R6 oversize cancel
        '{1'b0, 1'b1, 16'd80,  2'd1, 1'b1, 3'd0},  // R2 boundary sell
        '{1'b0, 1'b0, 16'd100, 2'd2, 1'b0, 3'd2}   // R1 boundary qty, R2 reject
    };

    task automatic send_check(input logic c, input logic s, input logic [QTY_W-1:0] q,
                              input logic [IDX_W-1:0] i, input logic ep,
                              input logic [2:0] er, input string tag);
        req_valid = 1'b1; req_cancel = c; req_sell = s; req_qty = q; req_inst = i;
        @(negedge clk);
        req_valid = 1'b0; req_cancel = 1'b0;
        @(negedge clk);
        n_tests++;
        if (res_valid !== 1'b1 || res_pass !== ep || res_reason !== er) begin
            n_fail++;
            $display("FAIL %s: valid=%0d pass=%0d reason=%0d expected valid=1 pass=%0d reason=%0d",
                     tag, res_valid, res_pass, res_reason, ep, er);
        end
    endtask

    task automatic do_fill(input logic s, input logic [QTY_W-1:0] q,
                           input logic [IDX_W-1:0] i, input int p);
        fill_valid = 1'b1; fill_sell = s; fill_qty = q; fill_inst = i; fill_pnl = p;
        @(negedge clk);
        fill_valid = 1'b0; fill_pnl = '0;
    endtask

    task automatic pulse_sec();
        tick_sec = 1'b1; @(negedge clk); tick_sec = 1'b0;
    endtask
    task automatic pulse_min();
        tick_min = 1'b1; @(negedge clk); tick_min = 1'b0;
    endtask
    task automatic pulse_day();
        day_reset = 1'b1; @(negedge clk); day_reset = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        n_tests++;
        if (res_valid !== 1'b0 || res_pass !== 1'b0 || res_reason !== 3'd0) begin
            n_fail++;
            $display("FAIL R9 reset: valid=%0d pass=%0d reason=%0d expected 0 0 0",
                     res_valid, res_pass, res_reason);
        end

        for (int k = 0; k < 8; k++) begin
            send_check(VECS[k].cancel, VECS[k].sell, VECS[k].qty, VECS[k].inst,
                       VECS[k].pass, VECS[k].reason, $sformatf("table R1/R2/R6 row %0d", k));
        end

        // R7 fills move the net position of instrument 0
        do_fill(1'b0, 16'd60, 2'd0, 0);
        send_check(0, 0, 16'd30,  2'd0, 1'b0, 3'd2, "R7 long 60 + buy 30");
        send_check(0, 1, 16'd80,  2'd0, 1'b1, 3'd0, "R7 long 60 - sell 80");
        do_fill(1'b1, 16'd100, 2'd0, 0);
        send_check(0, 1, 16'd50,  2'd0, 1'b0, 3'd2, "R7 net -40 - sell 50");
        send_check(0, 0, 16'd100, 2'd0, 1'b1, 3'd0, "R7 net -40 + buy 100");
        send_check(0, 0, 16'd120, 2'd0, 1'b0, 3'd1, "R9 size over position");

        // R3 minute loss
        do_fill(1'b0, 16'd0, 2'd3, -300);
        do_fill(1'b0, 16'd0, 2'd3, 1000);
        do_fill(1'b0, 16'd0, 2'd3, -200);
        send_check(0, 0, 16'd10, 2'd3, 1'b1, 3'd0, "R3 loss at limit");
        do_fill(1'b0, 16'd0, 2'd3, -1);
        send_check(0, 0, 16'd10, 2'd3, 1'b0, 3'd3, "R3 loss over limit");
        pulse_min();
        send_check(0, 0, 16'd10, 2'd3, 1'b1, 3'd0, "R8 minute tick clears");

        // R4 daily loss
        pulse_day();
        do_fill(1'b0, 16'd0, 2'd3, -1000);
        pulse_min();
        send_check(0, 0, 16'd10, 2'd3, 1'b1, 3'd0, "R4 day at floor");
        do_fill(1'b0, 16'd0, 2'd3, -1);
        send_check(0, 0, 16'd10, 2'd3, 1'b0, 3'd4, "R4 day below floor");
        send_check(0, 0, 16'd101, 2'd3, 1'b0, 3'd1, "R9 size over day loss");
        pulse_day();
        send_check(0, 0, 16'd10, 2'd3, 1'b1, 3'd0, "R8 day reset clears");

        // R5 / R10 order rate
        lim_rate = 8'd3;
        pulse_sec();
        send_check(0, 0, 16'd101, 2'd3, 1'b0, 3'd1, "R10 rejected order");
        send_check(1, 0, 16'd10,  2'd3, 1'b1, 3'd0, "R10 cancel one");
        send_check(1, 1, 16'd10,  2'd3, 1'b1, 3'd0, "R10 cancel two");
        send_check(0, 0, 16'd10,  2'd3, 1'b1, 3'd0, "R5 order 1");
        send_check(0, 0, 16'd10,  2'd3, 1'b1, 3'd0, "R5 order 2");
        send_check(0, 0, 16'd10,  2'd3, 1'b1, 3'd0, "R10 order 3 after skips");
        send_check(0, 0, 16'd10,  2'd3, 1'b0, 3'd5, "R5 order 4 over rate");
        send_check(1, 0, 16'd10,  2'd3, 1'b1, 3'd0, "R6 cancel at rate limit");
        pulse_sec();
        send_check(0, 0, 16'd10,  2'd3, 1'b1, 3'd0, "R8 second tick clears");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule